// File: doc/BRIEF.md
# Rotating Read Output Register Bank

This block is the read return path of a memory built from four modules. On each read capture it takes the word from the module named by the select input. It writes that word into one of four holding registers, W, X, Y and Z, and then presents the word on the outgoing data bus.

The holding register is not chosen by the address. A free-running pointer steps through W, X, Y, Z and back to W, one step per capture, whichever module was read. While the output enable is low the bus carries zero. The registers keep their contents during that time.

The block also reports the index of the register that was loaded most recently. A downstream stage can use that index to tell which slot holds the current word.

Top module: `rotreg_bank`

## Requirements
- R1: While reset is applied, and after it ends with no capture, `lastIdx` is 3 (Z), all four holding registers are zero and `busData` is zero. The first capture after reset goes to W (index 0).
- R2: At a capture, the word stored is slice `modWords[16*k+15 : 16*k]`, where k is the value on `modSel`.
- R3: Successive captures load the registers in the order W=0, X=1, Y=2, Z=3, and Z is followed by W. `lastIdx` takes the index loaded, one clock edge after `capStrobe` is sampled high.
- R4: The pointer advances by exactly one position on every capture, whatever the value of `modSel`. Each capture loads exactly one register.
- R5: In a cycle with `capStrobe` low, changes on `modWords` and `modSel` have no effect: `lastIdx` and `busData` stay unchanged.
- R6: With `outEn` high, `busData` equals the word held in the register named by `lastIdx`. That word is visible from the clock edge that captured it.
- R7: With `outEn` low, `busData` is zero. Raising `outEn` again shows the held word unchanged.
- R8: A capture made while `outEn` is low still loads the register and advances the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| modWords | input | 64 | The four module read words, module k in bits 16k+15..16k |
| modSel | input | 2 | Index of the module whose word is captured |
| capStrobe | input | 1 | Capture strobe, one read operation per high cycle |
| outEn | input | 1 | Output enable for the bus data |
| busData | output | 16 | Word of the last loaded register, or zero when disabled |
| lastIdx | output | 2 | Index of the register loaded most recently (0=W .. 3=Z) |

## Verification
The assertions assume that `capStrobe`, `modSel`, `modWords` and `outEn` are stable at each rising edge and free of unknown values. They also assume that reset is held for at least one edge before any capture. The stimulus meets these conditions by changing every input a quarter period after the rising edge and by holding reset for several cycles. It mixes random captures, random module choices, random data and random enables with directed sequences: a full wrap of the rotation, idle cycles with changing data, and captures while the output is disabled.

// File: rtl/rotreg_pkg.sv
package rotreg_pkg;
  parameter int WORD_W  = 16;
  parameter int NUM_MOD = 4;
  parameter int NUM_REG = 4;

  localparam int SEL_W = $clog2(NUM_MOD);
  localparam int IDX_W = $clog2(NUM_REG);
  localparam int BUS_IN_W = WORD_W * NUM_MOD;

  // Strobes from the rotation control to the register datapath.
  typedef struct packed {
    logic               load;     // a capture happens this cycle
    logic [NUM_REG-1:0] loadHot;  // one-hot write enable of the target slot
    logic [IDX_W-1:0]   showIdx;  // slot that drives the bus
  } rotStrobe_t;
endpackage

// File: rtl/rotreg_ctrl.sv
module rotreg_ctrl
  import rotreg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             capStrobe,
  output rotStrobe_t       strobes,
  output logic [IDX_W-1:0] lastIdx
);
  localparam logic [IDX_W-1:0] FIRST_IDX = '0;
  localparam logic [IDX_W-1:0] FINAL_IDX = IDX_W'(NUM_REG - 1);

  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] stepIdx;

  assign stepIdx = (nextIdx == FINAL_IDX) ? FIRST_IDX : nextIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextIdx <= FIRST_IDX;
      lastIdx <= FINAL_IDX;
    end else if (capStrobe) begin
      lastIdx <= nextIdx;
      nextIdx <= stepIdx;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.load    = capStrobe;
    strobes.showIdx = lastIdx;
    for (int i = 0; i < NUM_REG; i++) begin
      strobes.loadHot[i] = capStrobe && (nextIdx == IDX_W'(i));
    end
  end

  // R3: each capture moves lastIdx one step around the ring
  assert_rotate_R3: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |=> lastIdx == (($past(lastIdx) == FINAL_IDX) ? FIRST_IDX
                                                             : $past(lastIdx) + 1'b1));

  // R5: no capture, no movement
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !capStrobe |=> $stable(lastIdx));

  // R4: exactly one slot written per capture, none otherwise
  assert_one_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |-> $countones(strobes.loadHot) == 1);
  assert_no_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.loadHot));
endmodule

// File: rtl/rotreg_dpath.sv
module rotreg_dpath
  import rotreg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rotStrobe_t          strobes,
  input  logic [BUS_IN_W-1:0] modWords,
  input  logic [SEL_W-1:0]    modSel,
  input  logic                outEn,
  output logic [WORD_W-1:0]   busData
);
  logic [WORD_W-1:0] muxWord;
  logic [WORD_W-1:0] bank [NUM_REG];
  logic [WORD_W-1:0] showWord;

  always_comb begin
    muxWord = '0;
    for (int m = 0; m < NUM_MOD; m++) begin
      if (modSel == SEL_W'(m)) muxWord = modWords[m*WORD_W +: WORD_W];
    end
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                   bank[g] <= '0;
      else if (strobes.loadHot[g]) bank[g] <= muxWord;
    end
  end

  assign showWord = bank[strobes.showIdx];
  assign busData  = outEn ? showWord : '0;

  // R6: the slot shown after a capture holds the word that was selected
  assert_show_loaded_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> showWord == $past(muxWord));
endmodule

// File: rtl/rotreg_bank.sv
module rotreg_bank
  import rotreg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [BUS_IN_W-1:0] modWords,
  input  logic [SEL_W-1:0]    modSel,
  input  logic                capStrobe,
  input  logic                outEn,
  output logic [WORD_W-1:0]   busData,
  output logic [IDX_W-1:0]    lastIdx
);
  rotStrobe_t strobes;

  rotreg_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .capStrobe (capStrobe),
    .strobes   (strobes),
    .lastIdx   (lastIdx)
  );

  rotreg_dpath uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .modWords (modWords),
    .modSel   (modSel),
    .outEn    (outEn),
    .busData  (busData)
  );

  // R5: with the output enabled throughout, idle cycles leave the bus unchanged
  assert_bus_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!capStrobe && outEn) |=> (outEn -> $stable(busData)));
endmodule

// File: tb/sim_rotreg_bank.sv
module sim_rotreg_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] modWords;
  logic [1:0]  modSel;
  logic        capStrobe;
  logic        outEn;
  logic [15:0] busData;
  logic [1:0]  lastIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [15:0] expReg [4];
  logic [1:0]  expLast;
  logic [1:0]  expPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotreg_bank u0 (
    .clk(clk), .rstN(rstN), .modWords(modWords), .modSel(modSel),
    .capStrobe(capStrobe), .outEn(outEn), .busData(busData), .lastIdx(lastIdx)
  );

  function automatic logic [15:0] pickWord(input logic [63:0] w, input logic [1:0] s);
    return w[s*16 +: 16];
  endfunction

  function automatic logic [15:0] expBus(input logic oe);
    return oe ? expReg[expLast] : 16'h0;
  endfunction

  task automatic checkOut(input string req);
    nChecks++;
    if (lastIdx !== expLast || busData !== expBus(outEn)) begin
      nFails++;
      $display("FAIL %s: lastIdx=%0d busData=%h expected lastIdx=%0d busData=%h",
               req, lastIdx, busData, expLast, expBus(outEn));
    end
  endtask

  // inputs change a quarter period after the edge, results checked before the next edge
  task automatic cycle(input bit cap, input logic [1:0] sel, input logic [63:0] w,
                       input bit oe, input string req);
    capStrobe = cap; modSel = sel; modWords = w; outEn = oe;
    #1 checkOut({req, " pre"});
    @(posedge clk);
    if (cap) begin
      expReg[expPtr] = pickWord(w, sel);
      expLast = expPtr;
      expPtr  = expPtr + 2'd1;
    end
    #(CLK_PERIOD/4);
    checkOut(req);
  endtask

  function automatic logic [63:0] rndWords();
    return {$urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; capStrobe = 1'b0; modSel = 2'd0; outEn = 1'b1;
    modWords = 64'h4444_3333_2222_1111;
    for (int i = 0; i < 4; i++) expReg[i] = 16'h0;
    expLast = 2'd3; expPtr = 2'd0;
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/4);
    checkOut("R1 in reset");
    rstN = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    checkOut("R1 after reset");

    // R3/R2: full wrap, each capture from a different module
    cycle(1, 2'd2, 64'hDDDD_CCCC_BBBB_AAAA, 1, "R3 W load R2");
    cycle(1, 2'd0, 64'h1D1D_1C1C_1B1B_1A1A, 1, "R3 X load R2");
    cycle(1, 2'd3, 64'h2D2D_2C2C_2B2B_2A2A, 1, "R3 Y load R2");
    cycle(1, 2'd1, 64'h3D3D_3C3C_3B3B_3A3A, 1, "R3 Z load R2");
    cycle(1, 2'd1, 64'h4D4D_4C4C_4B4B_4A4A, 1, "R3 wrap to W");
    // R4: same module twice still advances
    cycle(1, 2'd1, 64'h5D5D_5C5C_5B5B_5A5A, 1, "R4 same module advances");
    // R5: idle with changing data and select
    cycle(0, 2'd3, 64'hFFFF_EEEE_9999_8888, 1, "R5 idle hold");
    cycle(0, 2'd0, 64'h0123_4567_89AB_CDEF, 1, "R5 idle hold 2");
    // R7: disable then re-enable
    cycle(0, 2'd2, 64'h0, 0, "R7 disabled zero");
    cycle(0, 2'd2, 64'h0, 1, "R7 re-enabled");
    // R8: capture while disabled
    cycle(1, 2'd3, 64'hBEEF_0000_0000_0000, 0, "R8 capture while disabled");
    cycle(0, 2'd0, 64'h0, 1, "R8 R6 word shown");

    for (int n = 0; n < 400; n++) begin
      cycle(($urandom % 10) < 6, 2'($urandom), rndWords(), ($urandom % 4) != 0,
            "R6 random");
    end

    // R1: reset in mid-stream
    rstN = 1'b0; capStrobe = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    for (int i = 0; i < 4; i++) expReg[i] = 16'h0;
    expLast = 2'd3; expPtr = 2'd0;
    capStrobe = 1'b0; rstN = 1'b1; outEn = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    checkOut("R1 re-reset");
    cycle(1, 2'd2, 64'h0000_7777_0000_0000, 1, "R1 first load to W");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule